// File: doc/BRIEF.md
# Quad Wiper Register Command Engine

This block interprets a byte-framed serial command stream that controls four 8-bit wiper registers. Each wiper sits in front of four 8-bit stored slots, so the block holds sixteen stored bytes and four live settings. A serial front end, outside this block, turns the bus into whole bytes. It passes them in on `byte_valid`/`byte_data` and holds `frame_active` high while the chip select is asserted. It also forwards each serial clock that arrives during the step mode as a one-cycle `step_tick`, together with the data-line level on `step_dir`. Read results go back to the front end as a one-cycle `rd_valid` strobe with `rd_data`.

Every frame opens with an identification byte that carries the address of this instance. The second byte holds an opcode, a slot field and a channel field. Commands cover:
- reading and writing a wiper or a stored slot;
- copying between a slot and its wiper, for one channel or for all four together;
- a status read;
- a step mode in which each serial clock nudges one wiper up or down.

Any change to the stored slots waits until the frame closes. At that point the change takes effect and a one-cycle `nv_req` pulse asks an external write-cycle controller to run. Stored slots are plain flops. On reset they take a fixed pattern, and each wiper takes the contents of its slot 0.

Top module: `potq_engine`

## Requirements
- R1: After reset, stored slot s of channel c holds 16*c + 4*s + 3, each wiper c holds the value of its slot 0 (16*c + 3), and `rd_valid` and `nv_req` are low.
- R2: The first byte of a frame must equal {4'b0101, 2'b00, dev_addr}. If it does not, the rest of the frame changes no register and returns no data.
- R3: The second byte is {opcode[3:0], slot[1:0], channel[1:0]}. With opcode 1010, the third byte is written into the selected wiper, and `wiper_out` shows it on the cycle after that byte.
- R4: Opcode 1001 (read wiper) and opcode 1011 (read slot) raise `rd_valid` for one cycle, on the cycle after the second byte, with the addressed value on `rd_data`. The third byte of such a frame has no effect.
- R5: Opcode 1100 takes the third byte as new slot contents. The slot changes only when `frame_active` falls. `nv_req` pulses once, on the cycle after the fall.
- R6: Opcode 1101 copies the addressed slot into its wiper on the cycle after the second byte. Opcode 1110 copies the wiper into the addressed slot when the frame closes, and pulses `nv_req`.
- R7: Opcode 0001 loads every wiper from its own slot selected by the slot field. Opcode 1000 saves every wiper into its own slot selected by the slot field when the frame closes, and pulses `nv_req` once. Both are two-byte commands.
- R8: After opcode 0010, each `step_tick` moves the selected wiper by one: up when `step_dir` is 1 and down when it is 0. The wiper stops at 255 and at 0 and never wraps. The mode lasts until `frame_active` falls.
- R9: A second byte of 0101_0001 returns {7'b0, wip} on `rd_data` with a `rd_valid` pulse.
- R10: An unrecognised opcode, or a write frame that closes before its data byte, changes no wiper and no slot and raises no `nv_req`.
- R11: Wipers change only on an accepted byte or a `step_tick` in the step mode. `step_tick` outside the step mode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_active | input | 1 | High while a frame is open (chip select asserted) |
| byte_valid | input | 1 | One-cycle strobe for a received byte |
| byte_data | input | 8 | Received byte |
| step_tick | input | 1 | One-cycle strobe per serial clock during the step mode |
| step_dir | input | 1 | Data-line level for the step: 1 up, 0 down |
| dev_addr | input | 2 | Address set by the instance pins |
| wip | input | 1 | Write-in-progress flag from the write-cycle controller |
| rd_valid | output | 1 | One-cycle strobe for a byte to return |
| rd_data | output | 8 | Byte to return |
| nv_req | output | 1 | One-cycle request to start a stored-data write cycle |
| wiper_out | output | 4x8 | Live wiper settings, channel c at bits [8c+7:8c] |

## Verification
The bound checker watches several rules on every cycle:
- wipers hold still when there is neither a byte nor a tick;
- a step moves a wiper by at most one and stays clamped at both ends;
- read strobes only follow a byte accepted inside a frame;
- `nv_req` only follows a closing frame and never lasts two cycles.

Other behaviour can only be seen through the bench's scenarios, which compare results against a reference model: address and identity rejection, the deferral of slot changes to the close of the frame, the global copies, the status byte and the silence of unknown or truncated commands.

// File: rtl/potq_pkg.sv
package potq_pkg;

    localparam int NCH   = 4;
    localparam int NSLOT = 4;
    localparam int DW    = 8;
    localparam int CHW   = $clog2(NCH);
    localparam int SLW   = $clog2(NSLOT);
    localparam int BW    = 8;

    localparam logic [3:0] ID_NIBBLE   = 4'b0101;
    localparam logic [3:0] STATUS_TAIL = 4'b0001;

    localparam logic [3:0] OP_GLB_LOAD = 4'b0001;
    localparam logic [3:0] OP_STEP     = 4'b0010;
    localparam logic [3:0] OP_STATUS   = 4'b0101;
    localparam logic [3:0] OP_GLB_SAVE = 4'b1000;
    localparam logic [3:0] OP_RD_WIPER = 4'b1001;
    localparam logic [3:0] OP_WR_WIPER = 4'b1010;
    localparam logic [3:0] OP_RD_SLOT  = 4'b1011;
    localparam logic [3:0] OP_WR_SLOT  = 4'b1100;
    localparam logic [3:0] OP_LOAD     = 4'b1101;
    localparam logic [3:0] OP_SAVE     = 4'b1110;

    typedef enum logic [2:0] {
        FS_ID,
        FS_INSTR,
        FS_DATA,
        FS_STEP,
        FS_IGNORE
    } fstate_e;

    typedef enum logic [3:0] {
        ACT_NONE,
        ACT_WR_WIPER,
        ACT_LOAD,
        ACT_LOAD_ALL,
        ACT_RD_WIPER,
        ACT_RD_SLOT,
        ACT_RD_STATUS,
        ACT_STEP,
        ACT_CM_SLOT,
        ACT_CM_SAVE,
        ACT_CM_SAVE_ALL
    } act_e;

    typedef struct packed {
        act_e             kind;
        logic [CHW-1:0]   ch;
        logic [SLW-1:0]   slot;
        logic [DW-1:0]    data;
    } act_t;

    function automatic logic [DW-1:0] seed_value(input int c, input int s);
        return DW'(16 * c + 4 * s + 3);
    endfunction

    function automatic logic [DW-1:0] step_sat(input logic [DW-1:0] v, input logic up);
        logic [DW-1:0] r;
        if (up) r = (v == {DW{1'b1}}) ? v : v + 1'b1;
        else    r = (v == '0) ? v : v - 1'b1;
        return r;
    endfunction

    function automatic logic id_match(input logic [BW-1:0] b, input logic [1:0] addr);
        return (b[7:4] == ID_NIBBLE) && (b[3:2] == 2'b00) && (b[1:0] == addr);
    endfunction

    function automatic logic is_commit(input act_e k);
        return (k == ACT_CM_SLOT) || (k == ACT_CM_SAVE) || (k == ACT_CM_SAVE_ALL);
    endfunction

    function automatic logic is_read(input act_e k);
        return (k == ACT_RD_WIPER) || (k == ACT_RD_SLOT) || (k == ACT_RD_STATUS);
    endfunction

endpackage

// File: rtl/potq_decoder.sv
module potq_decoder
    import potq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           frame_active,
    input  logic           byte_valid,
    input  logic [BW-1:0]  byte_data,
    input  logic [1:0]     dev_addr,
    input  logic           step_tick,
    input  logic           step_dir,
    output act_t           act
);

    fstate_e          state, state_n;
    logic             fa_q;
    act_t             pend, pend_n;
    logic [3:0]       op_q, op_n;
    logic [CHW-1:0]   ch_q, ch_n;
    logic [SLW-1:0]   sl_q, sl_n;

    always_comb begin
        state_n = state;
        pend_n  = pend;
        op_n    = op_q;
        ch_n    = ch_q;
        sl_n    = sl_q;
        act     = '0;
        if (!frame_active) begin
            state_n = FS_ID;
            pend_n  = '0;
            if (fa_q) act = pend;
        end else begin
            case (state)
                FS_ID: begin
                    if (byte_valid)
                        state_n = id_match(byte_data, dev_addr) ? FS_INSTR : FS_IGNORE;
                end
                FS_INSTR: begin
                    if (byte_valid) begin
                        op_n    = byte_data[7:4];
                        sl_n    = byte_data[3:2];
                        ch_n    = byte_data[1:0];
                        state_n = FS_IGNORE;
                        case (byte_data[7:4])
                            OP_RD_WIPER: begin
                                act     = '{kind: ACT_RD_WIPER, ch: byte_data[1:0],
                                            slot: byte_data[3:2], data: '0};
                                state_n = FS_DATA;
                            end
                            OP_RD_SLOT: begin
                                act     = '{kind: ACT_RD_SLOT, ch: byte_data[1:0],
                                            slot: byte_data[3:2], data: '0};
                                state_n = FS_DATA;
                            end
                            OP_WR_WIPER, OP_WR_SLOT: state_n = FS_DATA;
                            OP_LOAD: act = '{kind: ACT_LOAD, ch: byte_data[1:0],
                                             slot: byte_data[3:2], data: '0};
                            OP_GLB_LOAD: act = '{kind: ACT_LOAD_ALL, ch: byte_data[1:0],
                                                 slot: byte_data[3:2], data: '0};
                            OP_SAVE: pend_n = '{kind: ACT_CM_SAVE, ch: byte_data[1:0],
                                                slot: byte_data[3:2], data: '0};
                            OP_GLB_SAVE: pend_n = '{kind: ACT_CM_SAVE_ALL, ch: byte_data[1:0],
                                                    slot: byte_data[3:2], data: '0};
                            OP_STEP: state_n = FS_STEP;
                            OP_STATUS: begin
                                if (byte_data[3:0] == STATUS_TAIL) begin
                                    act     = '{kind: ACT_RD_STATUS, ch: '0, slot: '0, data: '0};
                                    state_n = FS_DATA;
                                end
                            end
                            default: state_n = FS_IGNORE;
                        endcase
                    end
                end
                FS_DATA: begin
                    if (byte_valid) begin
                        state_n = FS_IGNORE;
                        if (op_q == OP_WR_WIPER)
                            act = '{kind: ACT_WR_WIPER, ch: ch_q, slot: sl_q, data: byte_data};
                        else if (op_q == OP_WR_SLOT)
                            pend_n = '{kind: ACT_CM_SLOT, ch: ch_q, slot: sl_q, data: byte_data};
                    end
                end
                FS_STEP: begin
                    if (step_tick)
                        act = '{kind: ACT_STEP, ch: ch_q, slot: sl_q,
                                data: {{(DW-1){1'b0}}, step_dir}};
                end
                default: state_n = FS_IGNORE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FS_ID;
            fa_q  <= 1'b0;
            pend  <= '0;
            op_q  <= '0;
            ch_q  <= '0;
            sl_q  <= '0;
        end else begin
            state <= state_n;
            fa_q  <= frame_active;
            pend  <= pend_n;
            op_q  <= op_n;
            ch_q  <= ch_n;
            sl_q  <= sl_n;
        end
    end

endmodule

// File: rtl/potq_channel.sv
module potq_channel
    import potq_pkg::*;
#(
    parameter int CH_IDX = 0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  act_t                        act,
    output logic [DW-1:0]               wiper,
    output logic [NSLOT-1:0][DW-1:0]    slots
);

    logic sel;
    assign sel = (act.ch == CHW'(CH_IDX));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSLOT; s++)
                slots[s] <= seed_value(CH_IDX, s);
            wiper <= seed_value(CH_IDX, 0);
        end else begin
            case (act.kind)
                ACT_WR_WIPER:    if (sel) wiper <= act.data;
                ACT_LOAD:        if (sel) wiper <= slots[act.slot];
                ACT_LOAD_ALL:    wiper <= slots[act.slot];
                ACT_STEP:        if (sel) wiper <= step_sat(wiper, act.data[0]);
                ACT_CM_SLOT:     if (sel) slots[act.slot] <= act.data;
                ACT_CM_SAVE:     if (sel) slots[act.slot] <= wiper;
                ACT_CM_SAVE_ALL: slots[act.slot] <= wiper;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/potq_engine.sv
module potq_engine
    import potq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      frame_active,
    input  logic                      byte_valid,
    input  logic [BW-1:0]             byte_data,
    input  logic                      step_tick,
    input  logic                      step_dir,
    input  logic [1:0]                dev_addr,
    input  logic                      wip,
    output logic                      rd_valid,
    output logic [BW-1:0]             rd_data,
    output logic                      nv_req,
    output logic [NCH-1:0][DW-1:0]    wiper_out
);

    act_t                               act;
    logic [NCH-1:0][NSLOT-1:0][DW-1:0]  slot_all;
    logic [BW-1:0]                      rd_sel;

    potq_decoder u_dec (
        .clk          (clk),
        .rst          (rst),
        .frame_active (frame_active),
        .byte_valid   (byte_valid),
        .byte_data    (byte_data),
        .dev_addr     (dev_addr),
        .step_tick    (step_tick),
        .step_dir     (step_dir),
        .act          (act)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        potq_channel #(.CH_IDX(c)) u_ch (
            .clk   (clk),
            .rst   (rst),
            .act   (act),
            .wiper (wiper_out[c]),
            .slots (slot_all[c])
        );
    end

    always_comb begin
        case (act.kind)
            ACT_RD_WIPER:  rd_sel = BW'(wiper_out[act.ch]);
            ACT_RD_SLOT:   rd_sel = BW'(slot_all[act.ch][act.slot]);
            ACT_RD_STATUS: rd_sel = {{(BW-1){1'b0}}, wip};
            default:       rd_sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            nv_req   <= 1'b0;
        end else begin
            rd_valid <= is_read(act.kind);
            nv_req   <= is_commit(act.kind);
            if (is_read(act.kind)) rd_data <= rd_sel;
        end
    end

endmodule

// File: rtl/potq_checker.sv
module potq_checker
    import potq_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      frame_active,
    input logic                      byte_valid,
    input logic                      step_tick,
    input logic                      step_dir,
    input logic                      rd_valid,
    input logic                      nv_req,
    input logic [NCH-1:0][DW-1:0]    wiper_out
);

    // R11: no byte and no tick means no wiper movement
    assert_wiper_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (!byte_valid && !step_tick) |=> $stable(wiper_out));

    // R4 and R9: a read strobe always follows a byte accepted inside a frame
    assert_read_follows_byte_R4: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(byte_valid && frame_active));

    // R5: a write-cycle request only follows a frame that has closed
    assert_req_after_close_R5: assert property (@(posedge clk) disable iff (rst)
        nv_req |-> !$past(frame_active));

    // R7: a single close gives a single-cycle request
    assert_req_single_R7: assert property (@(posedge clk) disable iff (rst)
        nv_req |=> !nv_req);

    for (genvar k = 0; k < NCH; k++) begin : g_chk
        // R8: stepping clamps at the top
        assert_ceiling_R8: assert property (@(posedge clk) disable iff (rst)
            (step_tick && step_dir && !byte_valid && wiper_out[k] == {DW{1'b1}})
            |=> wiper_out[k] == {DW{1'b1}});
        // R8: stepping clamps at the bottom
        assert_floor_R8: assert property (@(posedge clk) disable iff (rst)
            (step_tick && !step_dir && !byte_valid && wiper_out[k] == '0)
            |=> wiper_out[k] == '0);
        // R8: one tick moves a wiper by at most one
        assert_single_step_R8: assert property (@(posedge clk) disable iff (rst)
            (step_tick && !byte_valid) |=>
            (wiper_out[k] == $past(wiper_out[k]) ||
             wiper_out[k] == $past(wiper_out[k]) + 1'b1 ||
             wiper_out[k] == $past(wiper_out[k]) - 1'b1));
    end

endmodule

bind potq_engine potq_checker u_potq_checker (
    .clk          (clk),
    .rst          (rst),
    .frame_active (frame_active),
    .byte_valid   (byte_valid),
    .step_tick    (step_tick),
    .step_dir     (step_dir),
    .rd_valid     (rd_valid),
    .nv_req       (nv_req),
    .wiper_out    (wiper_out)
);

// File: tb/tb_potq_engine.sv
module tb_potq_engine;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic            rst;
    logic            frame_active, byte_valid, step_tick, step_dir, wip;
    logic [7:0]      byte_data;
    logic [1:0]      dev_addr;
    logic            rd_valid, nv_req;
    logic [7:0]      rd_data;
    logic [3:0][7:0] wiper_out;

    potq_engine dut (
        .clk(clk), .rst(rst), .frame_active(frame_active), .byte_valid(byte_valid),
        .byte_data(byte_data), .step_tick(step_tick), .step_dir(step_dir),
        .dev_addr(dev_addr), .wip(wip), .rd_valid(rd_valid), .rd_data(rd_data),
        .nv_req(nv_req), .wiper_out(wiper_out)
    );

    localparam logic [1:0] MY_ADDR = 2'b10;

    int n_chk = 0, n_fail = 0, rd_cnt = 0, nv_cnt = 0, m_nv = 0;
    logic [7:0] last_rd = 8'h00;
    bit done = 1'b0;
    logic [7:0] m_w [4];
    logic [7:0] m_s [4][4];

    always @(negedge clk) begin
        if (rd_valid) begin rd_cnt++; last_rd = rd_data; end
        if (nv_req) nv_cnt++;
    end

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    function automatic logic [7:0] ref_step(input logic [7:0] v, input bit up);
        if (up) return (v == 8'd255) ? v : v + 8'd1;
        return (v == 8'd0) ? v : v - 8'd1;
    endfunction

    task automatic send(input logic [7:0] b);
        @(negedge clk); byte_valid = 1'b1; byte_data = b;
        @(negedge clk); byte_valid = 1'b0;
    endtask

    task automatic open_frame(input logic [7:0] id);
        @(negedge clk); frame_active = 1'b1;
        send(id);
    endtask

    task automatic close_frame();
        @(negedge clk); frame_active = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] id, input logic [7:0] ins, input bit third,
                         input logic [7:0] d);
        open_frame(id);
        send(ins);
        if (third) send(d);
        close_frame();
    endtask

    function automatic logic [7:0] idb(input logic [1:0] a);
        return {4'b0101, 2'b00, a};
    endfunction

    task automatic check_wipers(input string req);
        for (int c = 0; c < 4; c++) chk(req, wiper_out[c], m_w[c]);
    endtask

    task automatic read_check(input string req, input logic [7:0] ins, input logic [7:0] exp);
        int c0;
        c0 = rd_cnt;
        frame(idb(MY_ADDR), ins, 1'b1, 8'hA5);
        chk({req, " strobe"}, rd_cnt - c0, 1);
        chk(req, last_rd, exp);
    endtask

    task automatic step_frame(input logic [1:0] p, input int n, input bit up);
        open_frame(idb(MY_ADDR));
        send({4'b0010, 2'b00, p});
        for (int i = 0; i < n; i++) begin
            @(negedge clk); step_tick = 1'b1; step_dir = up;
            @(negedge clk); step_tick = 1'b0;
            m_w[p] = ref_step(m_w[p], up);
        end
        close_frame();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL R11 watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; frame_active = 0; byte_valid = 0; byte_data = 0;
        step_tick = 0; step_dir = 0; wip = 0; dev_addr = MY_ADDR;
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 4; s++) m_s[c][s] = 8'(16 * c + 4 * s + 3);
            m_w[c] = m_s[c][0];
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset pattern and idle outputs
        check_wipers("R1 reset wiper");
        chk("R1 rd_valid idle", rd_valid, 0);
        chk("R1 nv_req idle", nv_req, 0);
        for (int c = 0; c < 4; c++)
            for (int s = 0; s < 4; s++)
                read_check("R1 R4 reset slot", {4'b1011, 2'(s), 2'(c)}, m_s[c][s]);

        // R3: write wiper
        frame(idb(MY_ADDR), {4'b1010, 2'b11, 2'd1}, 1'b1, 8'h5C); m_w[1] = 8'h5C;
        check_wipers("R3 write wiper");
        // R4: read wiper
        read_check("R4 read wiper", {4'b1001, 2'b00, 2'd1}, 8'h5C);

        // R5: write slot, deferred commit
        frame(idb(MY_ADDR), {4'b1100, 2'd2, 2'd3}, 1'b1, 8'hE1); m_s[3][2] = 8'hE1; m_nv++;
        chk("R5 nv_req count", nv_cnt, m_nv);
        read_check("R5 slot written", {4'b1011, 2'd2, 2'd3}, 8'hE1);

        // R6: single transfers
        frame(idb(MY_ADDR), {4'b1101, 2'd2, 2'd3}, 1'b0, 8'h00); m_w[3] = m_s[3][2];
        check_wipers("R6 slot to wiper");
        frame(idb(MY_ADDR), {4'b1110, 2'd1, 2'd1}, 1'b0, 8'h00); m_s[1][1] = m_w[1]; m_nv++;
        chk("R6 nv_req count", nv_cnt, m_nv);
        read_check("R6 wiper to slot", {4'b1011, 2'd1, 2'd1}, m_w[1]);

        // R7: global transfers
        frame(idb(MY_ADDR), {4'b1000, 2'd3, 2'd0}, 1'b0, 8'h00);
        for (int c = 0; c < 4; c++) m_s[c][3] = m_w[c];
        m_nv++;
        chk("R7 global save nv_req", nv_cnt, m_nv);
        for (int c = 0; c < 4; c++) read_check("R7 global save", {4'b1011, 2'd3, 2'(c)}, m_w[c]);
        frame(idb(MY_ADDR), {4'b0001, 2'd1, 2'd0}, 1'b0, 8'h00);
        for (int c = 0; c < 4; c++) m_w[c] = m_s[c][1];
        check_wipers("R7 global load");

        // R8: step with saturation at both ends
        frame(idb(MY_ADDR), {4'b1010, 2'b00, 2'd2}, 1'b1, 8'd253); m_w[2] = 8'd253;
        step_frame(2'd2, 5, 1'b1);
        chk("R8 ceiling", wiper_out[2], 255);
        frame(idb(MY_ADDR), {4'b1010, 2'b00, 2'd2}, 1'b1, 8'd2); m_w[2] = 8'd2;
        step_frame(2'd2, 4, 1'b0);
        chk("R8 floor", wiper_out[2], 0);
        check_wipers("R8 other channels");

        // R11: ticks outside the step mode
        open_frame(idb(MY_ADDR));
        send({4'b1001, 2'b00, 2'd0});
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); step_tick = 1'b1; step_dir = 1'b1;
            @(negedge clk); step_tick = 1'b0;
        end
        close_frame();
        @(negedge clk); step_tick = 1'b1; @(negedge clk); step_tick = 1'b0;
        @(negedge clk);
        check_wipers("R11 stray ticks");

        // R9: status
        wip = 1'b1;
        read_check("R9 status busy", 8'b0101_0001, 8'h01);
        wip = 1'b0;
        read_check("R9 status idle", 8'b0101_0001, 8'h00);

        // R2: address and identity rejection
        begin
            int c0;
            c0 = rd_cnt;
            frame(idb(2'b01), {4'b1010, 2'b00, 2'd0}, 1'b1, 8'h11);
            frame({4'b0110, 2'b00, MY_ADDR}, {4'b1010, 2'b00, 2'd0}, 1'b1, 8'h22);
            frame({4'b0101, 2'b01, MY_ADDR}, {4'b1010, 2'b00, 2'd0}, 1'b1, 8'h33);
            frame(idb(2'b00), {4'b1001, 2'b00, 2'd0}, 1'b1, 8'h00);
            frame(idb(2'b11), {4'b1100, 2'b00, 2'd0}, 1'b1, 8'h44);
            check_wipers("R2 rejected frames");
            chk("R2 no read strobe", rd_cnt - c0, 0);
            chk("R2 no nv_req", nv_cnt, m_nv);
        end

        // R10: unknown opcode and truncated writes
        frame(idb(MY_ADDR), {4'b0111, 2'b00, 2'd0}, 1'b1, 8'h77);
        frame(idb(MY_ADDR), {4'b0101, 2'b00, 2'd0}, 1'b1, 8'h78);
        frame(idb(MY_ADDR), {4'b1010, 2'b00, 2'd0}, 1'b0, 8'h00);
        frame(idb(MY_ADDR), {4'b1100, 2'b00, 2'd0}, 1'b0, 8'h00);
        open_frame(idb(MY_ADDR)); close_frame();
        check_wipers("R10 no wiper change");
        chk("R10 no nv_req", nv_cnt, m_nv);
        read_check("R10 slot kept", {4'b1011, 2'b00, 2'd0}, m_s[0][0]);

        // Random mix against the reference model
        for (int it = 0; it < 250; it++) begin
            int op;
            logic [1:0] p, r;
            logic [7:0] d;
            op = int'($urandom % 9);
            p  = 2'($urandom);
            r  = 2'($urandom);
            d  = 8'($urandom);
            case (op)
                0: begin frame(idb(MY_ADDR), {4'b1010, r, p}, 1'b1, d); m_w[p] = d; end
                1: read_check("R4 random read wiper", {4'b1001, r, p}, m_w[p]);
                2: read_check("R4 random read slot", {4'b1011, r, p}, m_s[p][r]);
                3: begin frame(idb(MY_ADDR), {4'b1100, r, p}, 1'b1, d); m_s[p][r] = d; m_nv++; end
                4: begin frame(idb(MY_ADDR), {4'b1101, r, p}, 1'b0, 8'h00); m_w[p] = m_s[p][r]; end
                5: begin frame(idb(MY_ADDR), {4'b1110, r, p}, 1'b0, 8'h00); m_s[p][r] = m_w[p]; m_nv++; end
                6: begin
                    frame(idb(MY_ADDR), {4'b0001, r, 2'b00}, 1'b0, 8'h00);
                    for (int c = 0; c < 4; c++) m_w[c] = m_s[c][r];
                end
                7: begin
                    frame(idb(MY_ADDR), {4'b1000, r, 2'b00}, 1'b0, 8'h00);
                    for (int c = 0; c < 4; c++) m_s[c][r] = m_w[c];
                    m_nv++;
                end
                default: step_frame(p, int'($urandom % 6), bit'($urandom % 2));
            endcase
            check_wipers("R3 R6 R7 R8 random wipers");
            chk("R5 random nv_req count", nv_cnt, m_nv);
        end
        for (int c = 0; c < 4; c++)
            for (int s = 0; s < 4; s++)
                read_check("R5 R6 R7 final slot", {4'b1011, 2'(s), 2'(c)}, m_s[c][s]);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule